// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution

This block produces the AES byte substitution and its inverse without a stored 256-entry table. Each incoming byte is moved by a linear change of basis into a three-level tower field. GF(2^2) uses elements a + bW with W^2 = 1 + W. GF(2^4) is built over it with X^2 = X + p. GF(2^8) is built over that with Y^2 = Y + r. The multiplicative inverse is taken in the tower using only GF(2^2) products and inversions, each a small function of a few input bits. The result is moved back to the standard polynomial basis.

The forward direction inverts and then applies the AES affine map with constant 0x63. The inverse direction applies the inverse affine map with constant 0x05 first and then inverts. Both directions share one inverter. A per-byte mode flag chooses the direction, so a round datapath can stream encryption and decryption bytes through the same instance, one byte per clock.

The basis-change matrices and the GF(2^8)-level constant are derived at elaboration from the GF(2^4) parameter. This keeps the arithmetic and the mapping consistent for either legal choice of p.

Top module: `sbox_tower`

## Requirements
- R1: With `in_inv` = 0, a valid input byte x yields S(x). S(x) is the inverse of x in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 taken as its own inverse, followed by the affine map. Output bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7 (indices modulo 8), XORed with bit i of 0x63.
- R2: With `in_inv` = 1, a valid input byte y yields the x for which S(x) = y.
- R3: The zero element is handled without a special path. Forward 0x00 gives 0x63, inverse 0x63 gives 0x00, and inverse 0x00 gives 0x52.
- R4: The result for a byte accepted on a clock edge appears with `out_valid` high exactly four clock edges later. `out_valid` is low in every cycle that does not correspond to an accepted byte.
- R5: A new byte is accepted on every clock. Consecutive bytes may each carry a different mode, and each result uses the mode sampled with its own byte.
- R6: While `rst` is high at a clock edge, `out_valid` and `out_byte` go to 0. Bytes already in flight are discarded and never produce `out_valid`.
- R7: `out_byte` keeps its last value in cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present this cycle |
| in_inv | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Result present this cycle |
| out_byte | output | 8 | Substituted byte, held while idle |

## Verification
The case hardest to reach from the ports is a dense mix of directions inside the pipeline. Four bytes can be in flight at once, each carrying its own mode, and a mode that slips by a stage would produce a plausible but wrong byte. The stimulus streams every byte value back to back in each direction. It then alternates the mode on every clock, so each stage holds a direction different from its neighbours. Reset is also asserted while two bytes are in flight, to show that they vanish.

// File: rtl/sbox_twr_pkg.sv
package sbox_twr_pkg;

  // GF(2^2): bit0 = a, bit1 = b, element a + bW with W^2 = 1 + W
  function automatic logic [1:0] gf4_mul(input logic [1:0] x, input logic [1:0] y);
    return {(x[1] & y[0]) ^ (x[0] & y[1]) ^ (x[1] & y[1]),
            (x[0] & y[0]) ^ (x[1] & y[1])};
  endfunction

  function automatic logic [1:0] gf4_inv(input logic [1:0] x);
    return {x[1], x[0] ^ x[1]};
  endfunction

  // GF(2^4) over GF(2^2): [1:0] low coefficient, [3:2] X coefficient, X^2 = X + p
  function automatic logic [3:0] gf16_mul(input logic [3:0] x, input logic [3:0] y,
                                          input logic [1:0] p);
    logic [1:0] hh;
    hh = gf4_mul(x[3:2], y[3:2]);
    return {gf4_mul(x[1:0], y[3:2]) ^ gf4_mul(x[3:2], y[1:0]) ^ hh,
            gf4_mul(x[1:0], y[1:0]) ^ gf4_mul(p, hh)};
  endfunction

  function automatic logic [3:0] gf16_inv(input logic [3:0] x, input logic [1:0] p);
    logic [1:0] nrm, ni;
    nrm = gf4_mul(x[1:0], x[1:0]) ^ gf4_mul(x[1:0], x[3:2]) ^
          gf4_mul(p, gf4_mul(x[3:2], x[3:2]));
    ni  = gf4_inv(nrm);
    return {gf4_mul(ni, x[3:2]), gf4_mul(ni, x[1:0] ^ x[3:2])};
  endfunction

  // GF(2^8) over GF(2^4): [3:0] low coefficient, [7:4] Y coefficient, Y^2 = Y + lam
  function automatic logic [7:0] gf256_mul(input logic [7:0] x, input logic [7:0] y,
                                           input logic [1:0] p, input logic [3:0] lam);
    logic [3:0] hh;
    hh = gf16_mul(x[7:4], y[7:4], p);
    return {gf16_mul(x[3:0], y[7:4], p) ^ gf16_mul(x[7:4], y[3:0], p) ^ hh,
            gf16_mul(x[3:0], y[3:0], p) ^ gf16_mul(lam, hh, p)};
  endfunction

  // Smallest lam for which Y^2 + Y + lam has no root in GF(2^4)
  function automatic logic [3:0] find_lambda(input logic [1:0] p);
    logic [3:0] res;
    logic       found, root;
    res   = 4'h0;
    found = 1'b0;
    for (int c = 1; c < 16; c++) begin
      root = 1'b0;
      for (int y = 0; y < 16; y++)
        if ((gf16_mul(4'(y), 4'(y), p) ^ 4'(y)) == 4'(c)) root = 1'b1;
      if (!root && !found) begin
        res   = 4'(c);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // Columns of the standard-to-tower matrix: powers of a tower root of the AES polynomial
  function automatic logic [63:0] map_cols(input logic [1:0] p, input logic [3:0] lam);
    logic [7:0]  beta, c2, c4, c8, pw;
    logic [63:0] cols;
    logic        found;
    beta  = 8'h00;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      c2 = gf256_mul(8'(c), 8'(c), p, lam);
      c4 = gf256_mul(c2, c2, p, lam);
      c8 = gf256_mul(c4, c4, p, lam);
      if (!found && (c8 ^ c4 ^ gf256_mul(c2, 8'(c), p, lam) ^ 8'(c) ^ 8'h01) == 8'h00) begin
        beta  = 8'(c);
        found = 1'b1;
      end
    end
    pw   = 8'h01;
    cols = '0;
    for (int i = 0; i < 8; i++) begin
      cols[i*8 +: 8] = pw;
      pw = gf256_mul(pw, beta, p, lam);
    end
    return cols;
  endfunction

  function automatic logic [7:0] mat_apply(input logic [63:0] cols, input logic [7:0] x);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 8; i++)
      if (x[i]) r = r ^ cols[i*8 +: 8];
    return r;
  endfunction

  // Columns of the inverse matrix, found by searching preimages of unit vectors
  function automatic logic [63:0] unmap_cols(input logic [63:0] fwd);
    logic [63:0] cols;
    cols = '0;
    for (int j = 0; j < 8; j++)
      for (int x = 0; x < 256; x++)
        if (mat_apply(fwd, 8'(x)) == (8'h01 << j)) cols[j*8 +: 8] = 8'(x);
    return cols;
  endfunction

  function automatic logic [7:0] affine_fwd(input logic [7:0] x);
    return x ^ {x[6:0], x[7]} ^ {x[5:0], x[7:6]} ^ {x[4:0], x[7:5]} ^
           {x[3:0], x[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] affine_inv(input logic [7:0] x);
    return {x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]} ^ 8'h05;
  endfunction

endpackage

// File: rtl/twr_map_in.sv
module twr_map_in
  import sbox_twr_pkg::*;
#(
  parameter logic [63:0] TO_COLS = 64'h0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic       in_mode,
  input  logic [7:0] in_byte,
  output logic       st_vld,
  output logic       st_mode,
  output logic [7:0] st_twr
);

  logic [7:0] pre;

  always_comb pre = in_mode ? affine_inv(in_byte) : in_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_vld  <= 1'b0;
      st_mode <= 1'b0;
      st_twr  <= 8'h00;
    end else begin
      st_vld  <= in_vld;
      st_mode <= in_mode;
      st_twr  <= mat_apply(TO_COLS, pre);
    end
  end

  AST_STAGE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (st_vld == $past(in_vld))); // R4

endmodule

// File: rtl/twr_inverter.sv
module twr_inverter
  import sbox_twr_pkg::*;
#(
  parameter logic [1:0] GF4_P = 2'd2,
  parameter logic [3:0] LAM   = 4'h0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic       in_mode,
  input  logic [7:0] in_twr,
  output logic       out_vld,
  output logic       out_mode,
  output logic [7:0] out_twr
);

  logic [3:0] nrm_c, ni_c;
  logic [3:0] a_nrm, a_hi, a_sum;
  logic       a_vld, a_mode;

  // stage A: norm of the GF(2^8) element over GF(2^4)
  always_comb
    nrm_c = gf16_mul(in_twr[3:0], in_twr[3:0], GF4_P) ^
            gf16_mul(in_twr[3:0], in_twr[7:4], GF4_P) ^
            gf16_mul(LAM, gf16_mul(in_twr[7:4], in_twr[7:4], GF4_P), GF4_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld  <= 1'b0;
      a_mode <= 1'b0;
      a_nrm  <= 4'h0;
      a_hi   <= 4'h0;
      a_sum  <= 4'h0;
    end else begin
      a_vld  <= in_vld;
      a_mode <= in_mode;
      a_nrm  <= nrm_c;
      a_hi   <= in_twr[7:4];
      a_sum  <= in_twr[7:4] ^ in_twr[3:0];
    end
  end

  // stage B: invert the norm, scale the conjugate
  always_comb ni_c = gf16_inv(a_nrm, GF4_P);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_mode <= 1'b0;
      out_twr  <= 8'h00;
    end else begin
      out_vld  <= a_vld;
      out_mode <= a_mode;
      out_twr  <= {gf16_mul(ni_c, a_hi, GF4_P), gf16_mul(ni_c, a_sum, GF4_P)};
    end
  end

  AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_twr == 8'h00) |-> ##2 (out_twr == 8'h00)); // R3
  AST_NONZERO_INV: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_twr != 8'h00) |-> ##2 (out_twr != 8'h00)); // R1

endmodule

// File: rtl/twr_map_out.sv
module twr_map_out
  import sbox_twr_pkg::*;
#(
  parameter logic [63:0] FROM_COLS = 64'h0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic       in_mode,
  input  logic [7:0] in_twr,
  output logic       out_vld,
  output logic [7:0] out_byte
);

  logic [7:0] std, res;

  always_comb begin
    std = mat_apply(FROM_COLS, in_twr);
    res = in_mode ? std : affine_fwd(std);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_byte <= 8'h00;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_byte <= res;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_byte)); // R7

endmodule

// File: rtl/sbox_tower.sv
module sbox_tower
  import sbox_twr_pkg::*;
#(
  parameter logic [1:0] GF4_P = 2'd2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_inv,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);

  localparam logic [3:0]  LAM       = find_lambda(GF4_P);
  localparam logic [63:0] TO_COLS   = map_cols(GF4_P, LAM);
  localparam logic [63:0] FROM_COLS = unmap_cols(TO_COLS);

  logic       m_vld, m_mode, i_vld, i_mode;
  logic [7:0] m_twr, i_twr;

  twr_map_in #(.TO_COLS(TO_COLS)) u_in (
    .clk(clk), .rst(rst), .in_vld(in_valid), .in_mode(in_inv), .in_byte(in_byte),
    .st_vld(m_vld), .st_mode(m_mode), .st_twr(m_twr));

  twr_inverter #(.GF4_P(GF4_P), .LAM(LAM)) u_inv (
    .clk(clk), .rst(rst), .in_vld(m_vld), .in_mode(m_mode), .in_twr(m_twr),
    .out_vld(i_vld), .out_mode(i_mode), .out_twr(i_twr));

  twr_map_out #(.FROM_COLS(FROM_COLS)) u_out (
    .clk(clk), .rst(rst), .in_vld(i_vld), .in_mode(i_mode), .in_twr(i_twr),
    .out_vld(out_valid), .out_byte(out_byte));

  AST_FWD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_inv && in_byte == 8'h00) |-> ##4 (out_valid && out_byte == 8'h63)); // R3
  AST_INV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_inv && in_byte == 8'h63) |-> ##4 (out_valid && out_byte == 8'h00)); // R3
  AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |-> ##4 out_valid); // R4

endmodule

// File: tb/tb_sbox_tower.sv
module tb_sbox_tower;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_inv;
  logic [7:0] in_byte;
  logic       out_valid;
  logic [7:0] out_byte;

  always #10 clk = ~clk;

  sbox_tower dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte));

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // {mode, input, expected}
  localparam logic [16:0] VEC [0:11] = '{
    17'h0_00_63, 17'h0_01_7c, 17'h0_53_ed, 17'h0_ff_16, 17'h0_10_ca, 17'h0_09_01,
    17'h1_63_00, 17'h1_00_52, 17'h1_ed_53, 17'h1_16_ff, 17'h1_01_09, 17'h1_7c_01};

  logic [7:0] inv_tab [0:255];
  logic       sv [0:299];
  logic       sm [0:299];
  logic [7:0] sd [0:299];
  logic [7:0] se [0:299];

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ t;
      t = t[7] ? ((t << 1) ^ 8'h1b) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_fwd(input logic [7:0] x);
    logic [7:0] v = 8'h01;
    logic [7:0] b;
    logic [7:0] c = 8'h63;
    if (x == 8'h00) v = 8'h00;
    else for (int i = 0; i < 254; i++) v = gmul(v, x);
    for (int i = 0; i < 8; i++)
      b[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic run_stream(input int n, input string req);
    logic [7:0] held = out_byte;
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        check(out_valid == sv[i-4], {req, " valid"}, {7'd0, out_valid}, {7'd0, sv[i-4]});
        if (sv[i-4]) begin
          check(out_byte == se[i-4], req, out_byte, se[i-4]);
          held = se[i-4];
        end else begin
          check(out_byte == held, {req, " R7 hold"}, out_byte, held);
        end
      end
      if (i < n) begin
        in_valid = sv[i]; in_inv = sm[i]; in_byte = sd[i];
      end else begin
        in_valid = 1'b0; in_inv = 1'b0; in_byte = 8'h00;
      end
    end
  endtask

  function automatic logic [7:0] expect_of(input logic m, input logic [7:0] d);
    return m ? inv_tab[d] : ref_fwd(d);
  endfunction

  initial begin
    for (int x = 0; x < 256; x++) inv_tab[ref_fwd(8'(x))] = 8'(x);
    rst = 1'b1; in_valid = 1'b1; in_inv = 1'b0; in_byte = 8'h00;

    // R6: reset with valid bytes presented
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R6 reset valid", {7'd0, out_valid}, 8'h00);
    check(out_byte == 8'h00, "R6 reset data", out_byte, 8'h00);
    rst = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6 after reset", {7'd0, out_valid}, 8'h00);
    end

    // R1 R2 R3: known-answer table
    for (int i = 0; i < 12; i++) begin
      sv[i] = 1'b1; sm[i] = VEC[i][16]; sd[i] = VEC[i][15:8]; se[i] = VEC[i][7:0];
    end
    run_stream(12, "R1,R2,R3 table");

    // R4: single byte, exact latency
    @(negedge clk);
    in_valid = 1'b1; in_inv = 1'b0; in_byte = 8'h53;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k < 4; k++) begin
      check(out_valid == 1'b0, "R4 early", {7'd0, out_valid}, 8'h00);
      @(negedge clk);
    end
    check(out_valid == 1'b1, "R4 on time", {7'd0, out_valid}, 8'h01);
    check(out_byte == 8'hed, "R4 data", out_byte, 8'hed);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 single pulse", {7'd0, out_valid}, 8'h00);

    // R1 R5: full forward sweep, back to back
    for (int i = 0; i < 256; i++) begin
      sv[i] = 1'b1; sm[i] = 1'b0; sd[i] = 8'(i); se[i] = ref_fwd(8'(i));
    end
    run_stream(256, "R1 forward sweep");

    // R2: full inverse sweep
    for (int i = 0; i < 256; i++) begin
      sv[i] = 1'b1; sm[i] = 1'b1; sd[i] = 8'(i); se[i] = inv_tab[i];
    end
    run_stream(256, "R2 inverse sweep");

    // R5: mode alternating every clock
    for (int i = 0; i < 64; i++) begin
      sv[i] = 1'b1; sm[i] = i[0]; sd[i] = 8'(i * 37 + 5);
      se[i] = expect_of(sm[i], sd[i]);
    end
    run_stream(64, "R5 mixed modes");

    // R7 R4: sparse valid with idle gaps
    for (int i = 0; i < 60; i++) begin
      sv[i] = (i % 3 == 0); sm[i] = (i % 6 == 3); sd[i] = 8'(i * 11 + 200);
      se[i] = expect_of(sm[i], sd[i]);
    end
    run_stream(60, "R7 gaps");

    // R6: reset while two bytes are in flight
    @(negedge clk);
    in_valid = 1'b1; in_inv = 1'b0; in_byte = 8'h01;
    @(negedge clk);
    in_byte = 8'h02;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_byte == 8'h00, "R6 mid-flight data", out_byte, 8'h00);
    for (int i = 0; i < 6; i++) begin
      check(out_valid == 1'b0, "R6 flushed", {7'd0, out_valid}, 8'h00);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule